// File: doc/BRIEF.md
# Serial Byte Transmitter with Buffer and Status Flags

This block is the transmit half of a serial channel. Software writes a byte into a one-entry holding buffer. When the shifter is idle the byte moves into it, and the shifter sends the byte out one bit per shift strike. The block reports two status flags: the buffer has emptied, and the shifter has finished.

The shift strike comes from one of two places:
- In framed mode it is an internal rate pulse. Each frame is a low start bit, then eight data bits LSB first, then a high stop bit.
- In clocked mode it is the falling edge of an external serial clock, brought into the system clock domain first. Each frame is the eight data bits with no framing.

The transmit-on bit starts and resets the transmit logic. A separate pin-select bit only decides whether the output pin shows the serial line or a general-purpose port value. The shifter keeps running behind a deselected pin. A sticky interrupt request follows a selectable flag. Turning transmit on also raises the request.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, buf_empty, shift_done, irq_req and proto_err are 0, and txd equals port_out.
- R2: A write to the enable register that turns transmit on from off sets buf_empty, shift_done and irq_req to 1 in the next cycle. This happens whichever interrupt source is selected.
- R3: In framed mode (cfg_sync=0), successive shift strikes drive the line with a 0 start bit, data bits 0 to 7, and then a 1 stop bit. The line is 1 whenever the shifter is idle.
- R4: In clocked mode with the external clock (cfg_sync=1, cfg_ext=1), the eight data bits go out LSB first with no start or stop bit. Each bit changes on a falling edge of sclk_in, seen through a two-flop synchroniser.
- R5: A buffer write accepted while transmit is on clears buf_empty in the next cycle. When the shifter is idle, the byte transfers one cycle later and buf_empty returns to 1. Buffer writes while transmit is off are ignored.
- R6: shift_done falls on the first shift strike after a byte enters the shifter. It rises on the strike that follows the last bit of the frame.
- R7: irq_req is sticky until irq_clr. While transmit is on, it is set only on a 0-to-1 change of the selected flag: buf_empty when cfg_irq_done=0, shift_done when cfg_irq_done=1.
- R8: The pin-select bit only chooses the pin source. With it at 0, txd shows port_out while shifting goes on. Setting it in the middle of a frame puts the current bit on txd.
- R9: Turning transmit off sets buf_empty and shift_done to 0, returns the line to idle 1, and drops any byte still held in the buffer.
- R10: A configuration write takes effect only while both transmit-on and receive-on are 0. At any other time it is ignored.
- R11: In external-clock mode, proto_err pulses for one cycle after a buffer write or a transmit turn-on made while the synchronised sclk_in is low.
- R12: A byte written during a frame stays in the buffer (buf_empty=0) until that frame ends. It then transfers and starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Internal shift strike, one cycle wide |
| sclk_in | input | 1 | External serial clock |
| en_wr | input | 1 | Enable register write strobe |
| en_tx | input | 1 | Transmit-on value |
| en_rx | input | 1 | Receive-on value (gates configuration only) |
| en_pin | input | 1 | Pin-select value: 1 gives the pin to the serial line |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sync | input | 1 | 1 selects clocked mode, 0 selects framed mode |
| cfg_ext | input | 1 | In clocked mode, 1 selects the external clock |
| cfg_irq_done | input | 1 | Interrupt source: 1 selects shift_done, 0 selects buf_empty |
| buf_wr | input | 1 | Buffer write strobe |
| buf_data | input | 8 | Byte to transmit |
| irq_clr | input | 1 | Clears irq_req |
| port_out | input | 1 | General-purpose value for the pin when it is deselected |
| txd | output | 1 | Output pin |
| buf_empty | output | 1 | Buffer-empty flag |
| shift_done | output | 1 | Shift-complete flag |
| irq_req | output | 1 | Sticky transmit interrupt request |
| proto_err | output | 1 | Pulses when a write breaks the clock-high rule |

## Verification
The hardest situation to reach from the ports is a byte that shifts out behind a deselected pin while transmit is on, after which the pin is handed back mid-frame. Getting there needs the pin-select bit to change through the shared enable register without making a transmit edge. The bench runs many random frames that start with the pin deselected and port_out at a random level. It rewrites the enable register partway through a frame and then checks that txd shows the expected bit of the partly shifted frame. The external-clock path is driven with slow sclk_in phases so that every synchronised falling edge yields exactly one strike.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
    typedef struct packed {
        logic sync_mode;
        logic ext_clk;
        logic irq_on_done;
    } tx_cfg_t;
endpackage

// File: rtl/ser_tx_clk.sv
module ser_tx_clk #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic baud_tick,
    input  logic use_ext,
    output logic sh_tick,
    output logic sclk_lvl
);
    localparam int CW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] chain;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CW-2:0], sclk_in};
        sclk_lvl   = st_q.chain[SYNC_STAGES-1];
        fall       = st_q.chain[SYNC_STAGES] & ~st_q.chain[SYNC_STAGES-1];
        sh_tick    = use_ext ? fall : baud_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              sync_mode,
    input  logic              tick,
    output logic              busy,
    output logic              line,
    output logic              frame_end,
    output logic              first_tick
);
    localparam int FW = DATA_W + 2;
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          line;
    } sh_st_t;

    sh_st_t        st_d, st_q;
    logic [CW-1:0] nbits;

    always_comb begin
        st_d       = st_q;
        frame_end  = 1'b0;
        first_tick = 1'b0;
        nbits      = sync_mode ? CW'(DATA_W) : CW'(FW);
        if (clr) begin
            st_d.sh   = '1;
            st_d.cnt  = '0;
            st_d.busy = 1'b0;
            st_d.line = 1'b1;
        end else if (load && !st_q.busy) begin
            st_d.sh   = sync_mode ? {2'b11, ld_data} : {1'b1, ld_data, 1'b0};
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.line = 1'b1;
        end else if (st_q.busy && tick) begin
            if (st_q.cnt == nbits) begin
                st_d.busy = 1'b0;
                st_d.line = 1'b1;
                frame_end = 1'b1;
            end else begin
                first_tick = (st_q.cnt == '0);
                st_d.line  = st_q.sh[0];
                st_d.sh    = {1'b1, st_q.sh[FW-1:1]};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
        busy = st_q.busy;
        line = st_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1, cnt: '0, busy: 1'b0, line: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              sclk_in,
    input  logic              en_wr,
    input  logic              en_tx,
    input  logic              en_rx,
    input  logic              en_pin,
    input  logic              cfg_wr,
    input  logic              cfg_sync,
    input  logic              cfg_ext,
    input  logic              cfg_irq_done,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              irq_clr,
    input  logic              port_out,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              irq_req,
    output logic              proto_err
);
    import ser_tx_pkg::*;

    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic              pin_en;
        tx_cfg_t           cfg;
        logic [DATA_W-1:0] hold;
        logic              pend;
        logic              empty;
        logic              done;
        logic              irq;
        logic              perr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic tx_rise, tx_fall, wr_ok, load, sh_clr, ext_mode;
    logic sh_tick, sclk_lvl, sh_busy, sh_line, frame_end, first_tick;
    logic be_rise, sd_rise, irq_set;
    logic tx_en_w;

    ser_tx_clk #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .baud_tick(baud_tick),
        .use_ext  (ext_mode),
        .sh_tick  (sh_tick),
        .sclk_lvl (sclk_lvl)
    );

    ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sh_clr),
        .load      (load),
        .ld_data   (st_q.hold),
        .sync_mode (st_q.cfg.sync_mode),
        .tick      (sh_tick),
        .busy      (sh_busy),
        .line      (sh_line),
        .frame_end (frame_end),
        .first_tick(first_tick)
    );

    always_comb begin
        st_d     = st_q;
        ext_mode = st_q.cfg.sync_mode & st_q.cfg.ext_clk;
        tx_rise  = en_wr & en_tx & ~st_q.tx_en;
        tx_fall  = en_wr & ~en_tx & st_q.tx_en;
        wr_ok    = buf_wr & st_q.tx_en & ~tx_fall;
        load     = st_q.tx_en & st_q.pend & ~sh_busy & ~tx_fall;
        sh_clr   = ~st_q.tx_en | tx_fall;

        if (en_wr) begin
            st_d.tx_en  = en_tx;
            st_d.rx_en  = en_rx;
            st_d.pin_en = en_pin;
        end
        if (cfg_wr && !st_q.tx_en && !st_q.rx_en) begin
            st_d.cfg.sync_mode   = cfg_sync;
            st_d.cfg.ext_clk     = cfg_ext;
            st_d.cfg.irq_on_done = cfg_irq_done;
        end

        if (load) begin
            st_d.pend  = 1'b0;
            st_d.empty = 1'b1;
        end
        if (wr_ok) begin
            st_d.hold  = buf_data;
            st_d.pend  = 1'b1;
            st_d.empty = 1'b0;
        end
        if (frame_end)  st_d.done = 1'b1;
        if (first_tick) st_d.done = 1'b0;

        if (tx_fall) begin
            st_d.pend  = 1'b0;
            st_d.empty = 1'b0;
            st_d.done  = 1'b0;
        end
        if (tx_rise) begin
            st_d.empty = 1'b1;
            st_d.done  = 1'b1;
        end

        be_rise = st_d.empty & ~st_q.empty;
        sd_rise = st_d.done & ~st_q.done;
        irq_set = tx_rise | (st_q.cfg.irq_on_done ? sd_rise : be_rise);
        if (irq_set)      st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;

        st_d.perr = ext_mode & ~sclk_lvl & ((buf_wr & st_q.tx_en) | tx_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_en_w    = st_q.tx_en;
    assign txd        = st_q.pin_en ? sh_line : port_out;
    assign buf_empty  = st_q.empty;
    assign shift_done = st_q.done;
    assign irq_req    = st_q.irq;
    assign proto_err  = st_q.perr;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en_wr,
    input logic en_tx,
    input logic buf_wr,
    input logic irq_clr,
    input logic tx_en_q,
    input logic buf_empty,
    input logic shift_done,
    input logic irq_req,
    input logic busy,
    input logic line
);
    // R2
    tx_on_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_tx && !tx_en_q) |=> (buf_empty && shift_done && irq_req));

    // R9
    tx_off_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_tx) |=> (!buf_empty && !shift_done && line));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clr) |=> irq_req);

    // R5
    wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && tx_en_q && !(en_wr && !en_tx)) |=> !buf_empty);

    // R6
    done_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_q && !shift_done) |-> busy);

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
endmodule

bind ser_tx_top ser_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_tx     (en_tx),
    .buf_wr    (buf_wr),
    .irq_clr   (irq_clr),
    .tx_en_q   (tx_en_w),
    .buf_empty (buf_empty),
    .shift_done(shift_done),
    .irq_req   (irq_req),
    .busy      (sh_busy),
    .line      (sh_line)
);

// File: tb/sim_ser_tx_top.sv
`timescale 1ns/1ps
module sim_ser_tx_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic baud_tick = 0, sclk_in = 1, en_wr = 0, en_tx = 0, en_rx = 0, en_pin = 0;
    logic cfg_wr = 0, cfg_sync = 0, cfg_ext = 0, cfg_irq_done = 0;
    logic buf_wr = 0, irq_clr = 0, port_out = 0;
    logic [7:0] buf_data = '0;
    logic txd, buf_empty, shift_done, irq_req, proto_err;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ser_tx_top u0 (.*);

    function automatic logic fbit(input logic [7:0] d, input int i, input bit sy);
        if (sy) return d[i];
        if (i == 0) return 1'b0;
        if (i == 9) return 1'b1;
        return d[i-1];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_en(input logic t, input logic r, input logic p);
        en_wr = 1; en_tx = t; en_rx = r; en_pin = p; cyc(); en_wr = 0;
    endtask

    task automatic set_cfg(input logic s, input logic e, input logic q);
        cfg_wr = 1; cfg_sync = s; cfg_ext = e; cfg_irq_done = q; cyc(); cfg_wr = 0;
    endtask

    task automatic put(input logic [7:0] d);
        buf_wr = 1; buf_data = d; cyc(); buf_wr = 0;
    endtask

    task automatic clear_irq();
        irq_clr = 1; cyc(); irq_clr = 0;
    endtask

    task automatic baud();
        baud_tick = 1; cyc(); baud_tick = 0;
    endtask

    task automatic sfall();
        sclk_in = 0; cyc(4); sclk_in = 1;
    endtask

    // run one framed-mode frame already loaded; pin selected
    task automatic run_async(input logic [7:0] d, input string req);
        for (int i = 0; i < 10; i++) begin
            baud();
            chk(req, txd, fbit(d, i, 0));
            if (i == 0) chk("R6 done clears on first strike", shift_done, 0);
            cyc($urandom % 3);
        end
        baud();
        chk("R6 done rises after stop", shift_done, 1);
        chk("R3 idle high", txd, 1);
    endtask

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        port_out = 1'b0;
        cyc(3);
        rst_n = 1;
        cyc();
        // R1
        chk("R1 buf_empty", buf_empty, 0);
        chk("R1 shift_done", shift_done, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 perr", proto_err, 0);
        port_out = 1; cyc();
        chk("R1 txd port", txd, 1);

        // R5 ignored write while off
        put(8'h55);
        chk("R5 write ignored when off", buf_empty, 0);

        // R2
        set_en(1, 0, 1);
        chk("R2 empty", buf_empty, 1);
        chk("R2 done", shift_done, 1);
        chk("R2 irq", irq_req, 1);
        baud();
        chk("R5 dropped write not sent", txd, 1);
        cyc(3);
        chk("R7 sticky", irq_req, 1);
        clear_irq();
        chk("R7 cleared", irq_req, 0);

        // R5 / R7 buffer-empty source / R3
        put(8'hA6);
        chk("R5 empty falls", buf_empty, 0);
        chk("R7 no irq on write", irq_req, 0);
        cyc();
        chk("R5 empty rises on transfer", buf_empty, 1);
        chk("R7 irq on empty rise", irq_req, 1);
        clear_irq();
        // R12 queue next byte mid-frame
        for (int i = 0; i < 4; i++) begin baud(); chk("R3 framed bit", txd, fbit(8'hA6, i, 0)); end
        put(8'h3C);
        for (int i = 4; i < 10; i++) begin
            baud(); chk("R3 framed bit", txd, fbit(8'hA6, i, 0));
            chk("R12 held until frame end", buf_empty, 0);
        end
        baud();
        cyc();
        chk("R12 transfer after frame", buf_empty, 1);
        run_async(8'h3C, "R12 second frame");
        chk("R7 no irq without rise", irq_req, 1);
        clear_irq(); cyc(4);
        chk("R7 stays clear", irq_req, 0);

        // R10 blocked by tx on
        set_cfg(0, 0, 1);
        put(8'h81); cyc();
        chk("R10 cfg ignored while tx on", irq_req, 1);
        run_async(8'h81, "R3 framed bit");
        // R10 blocked by rx on
        set_en(0, 1, 1);
        set_cfg(0, 0, 1);
        set_en(1, 0, 1); clear_irq();
        put(8'h12); cyc();
        chk("R10 cfg ignored while rx on", irq_req, 1);
        run_async(8'h12, "R3 framed bit");
        // R7 shift-done source
        set_en(0, 0, 1);
        set_cfg(0, 0, 1);
        set_en(1, 0, 1);
        chk("R2 irq regardless of source", irq_req, 1);
        clear_irq();
        put(8'hF0); cyc();
        chk("R7 no irq on empty with done source", irq_req, 0);
        for (int i = 0; i < 10; i++) baud();
        chk("R7 no irq mid frame", irq_req, 0);
        baud();
        chk("R7 irq on done rise", irq_req, 1);
        clear_irq();

        // R9 mid-frame turn-off
        put(8'h00); cyc(); baud(); baud(); baud();
        put(8'hFF);
        set_en(0, 0, 1);
        chk("R9 line idle", txd, 1);
        chk("R9 empty 0", buf_empty, 0);
        chk("R9 done 0", shift_done, 0);
        set_en(1, 0, 1);
        baud(); baud();
        chk("R9 pending byte dropped", txd, 1);
        clear_irq();
        set_en(0, 0, 1);
        set_cfg(0, 0, 0);
        set_en(1, 0, 1);

        // R8 random frames, pin deselected then handed back mid-frame
        for (int n = 0; n < 24; n++) begin
            bit mid;
            d = 8'($urandom);
            mid = 1'($urandom);
            port_out = 1'($urandom);
            set_en(1, 0, !mid);
            put(d); cyc();
            for (int i = 0; i < 10; i++) begin
                if (mid && i == 5) set_en(1, 0, 1);
                baud();
                if (mid && i < 5) chk("R8 port while deselected", txd, port_out);
                else chk("R8 frame bit on pin", txd, fbit(d, i, 0));
                cyc($urandom % 3);
            end
            baud();
            chk("R6 done after frame", shift_done, 1);
        end
        clear_irq();

        // R4 / R11 external clocked mode
        set_en(0, 0, 1);
        set_cfg(1, 1, 0);
        sclk_in = 1; cyc(4);
        set_en(1, 0, 1);
        chk("R11 no error when high", proto_err, 0);
        for (int f = 0; f < 3; f++) begin
            d = (f == 0) ? 8'hA5 : 8'($urandom);
            put(d);
            chk("R11 no error on high write", proto_err, 0);
            cyc();
            for (int i = 0; i < 8; i++) begin
                sfall();
                chk("R4 clocked bit", txd, fbit(d, i, 1));
                if (i == 0) chk("R6 done clears clocked", shift_done, 0);
                cyc(4);
            end
            sfall();
            chk("R4 idle after 8 bits", txd, 1);
            chk("R6 done clocked", shift_done, 1);
            cyc(4);
        end
        sclk_in = 0; cyc(4);
        put(8'h01);
        chk("R11 error on low write", proto_err, 1);
        cyc();
        chk("R11 one cycle pulse", proto_err, 0);
        set_en(0, 0, 1);
        set_en(1, 0, 1);
        chk("R11 error on low enable", proto_err, 1);
        sclk_in = 1; cyc(4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule